// File: doc/BRIEF.md
# Nine-bit address-filtering serial receiver

This block receives characters from a half-duplex multidrop serial line and filters them in hardware. The character carries a ninth bit that marks it as either an address or data. The receiver decodes every address character and compares it with the node address fixed by the parameter `NODE_ADDR`. A match selects the node, and any other address deselects it. Data characters reach the host only while the node is selected, so a host on an unaddressed node sees nothing of the traffic meant for its neighbours.

The host gets a strobe for every address character, with a flag that tells whether it matched. This keeps the work a node does per address small. A selected transfer ends in one of two ways. Either a new address character arrives, or `BURST_LEN` data characters have been forwarded. Setting `BURST_LEN` to 0 turns the count limit off. A bad stop bit raises a framing-error pulse, drops the character and deselects the node.

Top module: `mark9_node_rx`

## Requirements
- R1: After reset `out_valid`, `out_frame_err` and `out_selected` are 0, and the node stays deselected until a matching address character is received.
- R2: A character is one low start bit, 8 data bits least significant first, the mark bit, and one high stop bit, each `16*DIV` clocks long. The line passes through a two-flop synchronizer. Each bit is decided by a majority of three samples near mid-bit, so a disturbance shorter than one sample spacing does not change the received value.
- R3: Every character whose mark bit is 1 produces a one-cycle `out_valid` with `out_is_addr`=1 and `out_data` equal to its 8 data bits. `out_addr_hit` is 1 in that cycle exactly when the data equals `NODE_ADDR`.
- R4: A matching address character sets `out_selected`, and a non-matching address character clears it.
- R5: A data character (mark bit 0) received while deselected produces no `out_valid` and does not change `out_selected`.
- R6: A data character received while selected produces a one-cycle `out_valid` with `out_is_addr`=0, `out_addr_hit`=0 and `out_data` equal to its 8 data bits.
- R7: When `BURST_LEN` is nonzero, the `BURST_LEN`-th data character forwarded after a matching address is still delivered and clears `out_selected`, so later data characters are discarded.
- R8: A low level that is high again at the middle of the start bit is rejected without any strobe, and the receiver accepts the next character normally.
- R9: A character whose stop bit samples low produces a one-cycle `out_frame_err` without `out_valid`, and clears `out_selected`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial line, idle high |
| out_valid | output | 1 | One-cycle strobe for a delivered character |
| out_data | output | 8 | Data bits of the delivered character |
| out_is_addr | output | 1 | Delivered character is an address |
| out_addr_hit | output | 1 | Delivered address equals `NODE_ADDR` |
| out_frame_err | output | 1 | One-cycle pulse on a bad stop bit |
| out_selected | output | 1 | Node currently selected |

## Verification
On every cycle the assertions check how the output flags relate to each other:
- A hit occurs only on an address strobe.
- A hit leaves the node selected.
- A data strobe happens only if the node was selected the cycle before.
- A framing error never coincides with a strobe and always leaves the node deselected.
- Strobes last one cycle.

Only the bench scenarios can show the rest. That covers the serial timing and bit order, the majority vote tolerating a short disturbance, glitch rejection, silent discarding of data while deselected, and the count limit ending a transfer.

// File: rtl/mark9_node_rx.sv
`timescale 1ns/1ps
module mark9_node_rx #(
  parameter int          DIV       = 4,
  parameter logic [7:0]  NODE_ADDR = 8'h5A,
  parameter int          BURST_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_is_addr,
  output logic       out_addr_hit,
  output logic       out_frame_err,
  output logic       out_selected
);
  localparam int DW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int CW   = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam int LAST = (BURST_LEN > 0) ? BURST_LEN - 1 : 0;

  typedef enum logic [1:0] {IDLE, START, BITS, STOP} st_t;
  st_t st;

  logic [1:0]    sy;
  logic [DW-1:0] dcnt;
  logic [3:0]    sub;
  logic [3:0]    bidx;
  logic [8:0]    shreg;
  logic [1:0]    smp;
  logic [CW-1:0] cnt;

  wire rxs   = sy[1];
  wire tick  = (dcnt == DW'(DIV - 1));
  wire vote  = (smp[1] & smp[0]) | (smp[1] & rxs) | (smp[0] & rxs);
  wire limit = (BURST_LEN != 0) && (cnt == CW'(LAST));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sy <= 2'b11;
    else        sy <= {sy[0], rx_line};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    dcnt <= '0;
    else if (tick) dcnt <= '0;
    else           dcnt <= dcnt + DW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; sub <= '0; bidx <= '0; shreg <= '0; smp <= '0; cnt <= '0;
      out_valid <= 1'b0; out_data <= '0; out_is_addr <= 1'b0;
      out_addr_hit <= 1'b0; out_frame_err <= 1'b0; out_selected <= 1'b0;
    end else begin
      out_valid     <= 1'b0;
      out_is_addr   <= 1'b0;
      out_addr_hit  <= 1'b0;
      out_frame_err <= 1'b0;
      if (tick) begin
        if (st == IDLE) begin
          if (!rxs) begin
            st  <= START;
            sub <= 4'd1;
          end
        end else begin
          sub <= sub + 4'd1;
          if (sub == 4'd7 || sub == 4'd8) smp <= {smp[0], rxs};
          if (sub == 4'd9) begin
            case (st)
              START: if (vote) st <= IDLE;
              BITS:  shreg <= {vote, shreg[8:1]};
              STOP: begin
                st <= IDLE;
                if (!vote) begin
                  out_frame_err <= 1'b1;
                  out_selected  <= 1'b0;
                end else if (shreg[8]) begin
                  out_valid    <= 1'b1;
                  out_is_addr  <= 1'b1;
                  out_data     <= shreg[7:0];
                  out_addr_hit <= (shreg[7:0] == NODE_ADDR);
                  out_selected <= (shreg[7:0] == NODE_ADDR);
                  cnt          <= '0;
                end else if (out_selected) begin
                  out_valid <= 1'b1;
                  out_data  <= shreg[7:0];
                  cnt       <= cnt + CW'(1);
                  if (limit) out_selected <= 1'b0;
                end
              end
              default: ;
            endcase
          end
          if (sub == 4'd15) begin
            if (st == START) begin
              st   <= BITS;
              bidx <= '0;
            end else if (st == BITS) begin
              if (bidx == 4'd8) st <= STOP;
              else              bidx <= bidx + 4'd1;
            end
          end
        end
      end
    end
  end

  a_r3_hit_is_addr: assert property (@(posedge clk) disable iff (!rst_n)
    out_addr_hit |-> (out_valid && out_is_addr));
  a_r4_hit_selects: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_addr_hit) |-> out_selected);
  a_r5_data_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_addr) |-> $past(out_selected));
  a_r9_err_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    out_frame_err |-> (!out_valid && !out_selected));
  a_r6_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  a_r9_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    out_frame_err |=> !out_frame_err);
endmodule

// File: tb/mark9_node_rx_tb.sv
`timescale 1ns/1ps
module mark9_node_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_line = 1'b1;
  logic out_valid, out_is_addr, out_addr_hit, out_frame_err, out_selected;
  logic [7:0] out_data;

  always #5 clk = ~clk;

  mark9_node_rx #(.DIV(4), .NODE_ADDR(8'h5A), .BURST_LEN(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .out_valid(out_valid),
    .out_data(out_data), .out_is_addr(out_is_addr), .out_addr_hit(out_addr_hit),
    .out_frame_err(out_frame_err), .out_selected(out_selected));

  int n_chk = 0, n_bad = 0, ev_cnt = 0, fe_cnt = 0;
  logic [7:0] ev_data = '0;
  logic ev_addr = 1'b0, ev_hit = 1'b0;
  bit done = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin
      ev_cnt++; ev_data = out_data; ev_addr = out_is_addr; ev_hit = out_addr_hit;
    end
    if (out_frame_err) fe_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [8:0] ch, input bit stop_ok, input int gbit);
    rx_line = 1'b0; #640;
    for (int i = 0; i < 9; i++) begin
      if (i == gbit) begin
        rx_line = ch[i]; #330; rx_line = ~ch[i]; #30; rx_line = ch[i]; #280;
      end else begin
        rx_line = ch[i]; #640;
      end
    end
    rx_line = stop_ok; #640;
    rx_line = 1'b1; #1280;
  endtask

  // {stop_ok, char[8:0], exp_event, exp_is_addr, exp_hit, exp_selected}
  localparam logic [13:0] VEC [17] = '{
    {1'b1, 9'h033, 4'b0000},  // R5 data while deselected
    {1'b1, 9'h117, 4'b1100},  // R3 foreign address
    {1'b1, 9'h044, 4'b0000},  // R5
    {1'b1, 9'h15A, 4'b1111},  // R3 R4 own address
    {1'b1, 9'h0A5, 4'b1001},  // R6
    {1'b1, 9'h000, 4'b1001},  // R6
    {1'b1, 9'h117, 4'b1100},  // R4 foreign address deselects
    {1'b1, 9'h0FF, 4'b0000},  // R5
    {1'b1, 9'h15A, 4'b1111},  // R4
    {1'b0, 9'h081, 4'b0000},  // R9 bad stop
    {1'b1, 9'h012, 4'b0000},  // R9 stays deselected
    {1'b1, 9'h15A, 4'b1111},  // R7 burst start
    {1'b1, 9'h001, 4'b1001},
    {1'b1, 9'h002, 4'b1001},
    {1'b1, 9'h003, 4'b1001},
    {1'b1, 9'h004, 4'b1000},  // R7 last of burst deselects
    {1'b1, 9'h005, 4'b0000}   // R7 discarded after limit
  };

  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int e0, f0;
    #103 rst_n = 1'b1;
    #200;
    chk("R1 valid after reset", out_valid, 0);
    chk("R1 selected after reset", out_selected, 0);
    chk("R1 frame_err after reset", out_frame_err, 0);
    chk("R1 no events", ev_cnt, 0);

    for (int i = 0; i < 17; i++) begin
      e0 = ev_cnt; f0 = fe_cnt;
      send(VEC[i][12:4], VEC[i][13], -1);
      chk($sformatf("R3/R5/R6 event count vec %0d", i), ev_cnt - e0, int'(VEC[i][3]));
      chk($sformatf("R4/R7 selected vec %0d", i), out_selected, int'(VEC[i][0]));
      chk($sformatf("R9 frame err vec %0d", i), fe_cnt - f0, int'(!VEC[i][13]));
      if (VEC[i][3]) begin
        chk($sformatf("R2 data vec %0d", i), ev_data, int'(VEC[i][11:4]));
        chk($sformatf("R3 is_addr vec %0d", i), ev_addr, int'(VEC[i][2]));
        chk($sformatf("R3 hit vec %0d", i), ev_hit, int'(VEC[i][1]));
      end
    end

    // R8: short low pulse on idle line is rejected, then a real frame is accepted
    e0 = ev_cnt; f0 = fe_cnt;
    rx_line = 1'b0; #80; rx_line = 1'b1; #2000;
    chk("R8 glitch no event", ev_cnt - e0, 0);
    chk("R8 glitch no frame err", fe_cnt - f0, 0);
    send(9'h15A, 1'b1, -1);
    chk("R8 rearmed event", ev_cnt - e0, 1);
    chk("R8 rearmed selected", out_selected, 1);

    // R2: short disturbance at mid-bit does not change the bit
    e0 = ev_cnt;
    send(9'h03C, 1'b1, 2);
    chk("R2 vote event", ev_cnt - e0, 1);
    chk("R2 vote data", ev_data, 8'h3C);
    send(9'h0C3, 1'b1, 7);
    chk("R2 vote data msb", ev_data, 8'hC3);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule